// File: doc/BRIEF.md
# Interrupt Pending and Vector Arbiter

This block keeps the per-line interrupt status of a processor core and decides when a hardware interrupt is to be taken. Lines 2 to 12 follow level-sensitive hardware request inputs, sampled every cycle. Lines 0 and 1 are software interrupts, set and cleared through an indexed write port. A local-enable mask selects which status bits may cause an interrupt. A "has work" flag tells a sleeping core that an enabled interrupt is waiting.

Delivery also needs the global interrupt-enable input high and the debug-mode input low. When all three conditions first hold together, the block emits a one-cycle take strobe. With the strobe it registers the winning vector, which is the highest-numbered enabled pending line. It also registers the handler address, found from an entry base and a programmable power-of-two vector spacing.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Status bit i, for i in 2..12, equals the value that `hw_irq_i[i-2]` held at the previous rising clock edge.
- R2: A software write (`sw_we_i`=1) with `sw_idx_i` below 2 loads `sw_level_i` into status bit `sw_idx_i` at the next edge. A write with any index from 2 to 31 changes no status bit.
- R3: `has_work_o` is 1 exactly when the AND of the status bits and the enable mask is nonzero. This holds whatever the values of `ie_i` and `dbg_i`.
- R4: `take_o` rises only in the cycle after the condition (has_work and `ie_i`=1 and `dbg_i`=0) first becomes true. It stays high for exactly one cycle. It does not assert again until the condition has gone false.
- R5: With `take_o`, `vector_o` gives the index of the most significant set bit of the masked status that was sampled at the same edge.
- R6: The stride is 0 when the spacing is 0, and `4 << spacing` bytes otherwise. `handler_o` = `entry_base_i` + (64 + vector) × stride, taken modulo 2^32.
- R7: Reset clears the status bits, the enable mask, the spacing and `take_o`.
- R8: `mask_we_i` loads `mask_i` into the enable mask, and `spacing_we_i` loads `spacing_i` (3 bits) into the spacing. Both take effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_irq_i | input | 11 | Hardware request levels for lines 2..12 |
| sw_we_i | input | 1 | Software status write strobe |
| sw_idx_i | input | 5 | Status bit index for the software write |
| sw_level_i | input | 1 | Level written by the software write |
| mask_we_i | input | 1 | Enable mask write strobe |
| mask_i | input | 13 | New enable mask |
| spacing_we_i | input | 1 | Vector spacing write strobe |
| spacing_i | input | 3 | New vector spacing |
| entry_base_i | input | 32 | Handler entry base address |
| ie_i | input | 1 | Global interrupt enable |
| dbg_i | input | 1 | Core is in debug mode |
| status_o | output | 13 | Interrupt status bits |
| has_work_o | output | 1 | An enabled interrupt is pending |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| vector_o | output | 4 | Selected vector, valid with take_o |
| handler_o | output | 32 | Handler address, valid with take_o |

## Verification
The hardest situation to reach from the ports is a status word in which a chosen top bit is set together with an arbitrary pattern of lower bits, including both software bits. That word must be present while delivery is still blocked, so that one fresh rising edge of the take condition exposes the arbitration. The stimulus holds `ie_i` low while it drives the hardware lines and writes the two software bits one at a time. It then raises `ie_i` for one cycle. This is repeated for every vector under every spacing value, and the expected address is recomputed arithmetically.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned EXT_OFFSET_DEF = 64;

  // byte distance between adjacent vector slots
  function automatic logic [31:0] stride_bytes(input logic [7:0] sp);
    return (sp == 8'd0) ? 32'd0 : (32'd4 << sp);
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N_LINES = 13,
  parameter int unsigned N_SW    = 2,
  parameter int unsigned IDX_W   = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_LINES-N_SW-1:0] hw_irq_i,
  input  logic                    sw_we_i,
  input  logic [IDX_W-1:0]        sw_idx_i,
  input  logic                    sw_level_i,
  output logic [N_LINES-1:0]      status_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_bit
    if (i < N_SW) begin : g_sw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_o[i] <= 1'b0;
        else if (sw_we_i && sw_idx_i == IDX_W'(i)) status_o[i] <= sw_level_i;
      end
    end else begin : g_hw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_o[i] <= 1'b0;
        else         status_o[i] <= hw_irq_i[i-N_SW];
      end
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned N_LINES = 13,
  parameter int unsigned SP_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               spacing_we_i,
  input  logic [SP_W-1:0]    spacing_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [SP_W-1:0]    spacing_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o    <= '0;
      spacing_o <= '0;
    end else begin
      if (mask_we_i)    mask_o    <= mask_i;
      if (spacing_we_i) spacing_o <= spacing_i;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_LINES = 13,
  localparam int unsigned VEC_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] pend_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N_LINES; k++) begin
      if (pend_i[k]) idx_o = VEC_W'(k);  // later (higher) index wins
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int unsigned VEC_W      = 4,
  parameter int unsigned SP_W       = 3,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned EXT_OFFSET = irq_arb_pkg::EXT_OFFSET_DEF
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SP_W-1:0]   spacing_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] stride, slot;
  assign stride = ADDR_W'(irq_arb_pkg::stride_bytes(8'(spacing_i)));
  assign slot   = ADDR_W'(EXT_OFFSET) + ADDR_W'(vec_i);
  assign addr_o = base_i + slot * stride;
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int unsigned N_LINES    = 13,
  parameter int unsigned N_SW       = 2,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned SP_W       = 3,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned EXT_OFFSET = irq_arb_pkg::EXT_OFFSET_DEF,
  localparam int unsigned VEC_W     = $clog2(N_LINES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_LINES-N_SW-1:0] hw_irq_i,
  input  logic                    sw_we_i,
  input  logic [IDX_W-1:0]        sw_idx_i,
  input  logic                    sw_level_i,
  input  logic                    mask_we_i,
  input  logic [N_LINES-1:0]      mask_i,
  input  logic                    spacing_we_i,
  input  logic [SP_W-1:0]         spacing_i,
  input  logic [ADDR_W-1:0]       entry_base_i,
  input  logic                    ie_i,
  input  logic                    dbg_i,
  output logic [N_LINES-1:0]      status_o,
  output logic                    has_work_o,
  output logic                    take_o,
  output logic [VEC_W-1:0]        vector_o,
  output logic [ADDR_W-1:0]       handler_o
);
  logic [N_LINES-1:0] mask_q;
  logic [SP_W-1:0]    spacing_q;
  logic [VEC_W-1:0]   win_idx;
  logic [ADDR_W-1:0]  win_addr;
  logic               deliver, deliver_q;

  irq_status_bank #(.N_LINES(N_LINES), .N_SW(N_SW), .IDX_W(IDX_W)) i_status (
    .clk_i, .rst_ni, .hw_irq_i, .sw_we_i, .sw_idx_i, .sw_level_i,
    .status_o
  );

  irq_cfg_regs #(.N_LINES(N_LINES), .SP_W(SP_W)) i_cfg (
    .clk_i, .rst_ni, .mask_we_i, .mask_i, .spacing_we_i, .spacing_i,
    .mask_o(mask_q), .spacing_o(spacing_q)
  );

  irq_prio_enc #(.N_LINES(N_LINES)) i_prio (
    .pend_i(status_o & mask_q), .any_o(has_work_o), .idx_o(win_idx)
  );

  irq_vec_addr #(.VEC_W(VEC_W), .SP_W(SP_W), .ADDR_W(ADDR_W),
                 .EXT_OFFSET(EXT_OFFSET)) i_addr (
    .base_i(entry_base_i), .spacing_i(spacing_q), .vec_i(win_idx),
    .addr_o(win_addr)
  );

  assign deliver = has_work_o && ie_i && !dbg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliver_q <= 1'b0;
      take_o    <= 1'b0;
      vector_o  <= '0;
      handler_o <= '0;
    end else begin
      deliver_q <= deliver;
      take_o    <= deliver && !deliver_q;
      if (deliver && !deliver_q) begin
        vector_o  <= win_idx;
        handler_o <= win_addr;
      end
    end
  end
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk #(
  parameter int unsigned N_LINES = 13,
  parameter int unsigned N_SW    = 2,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned SP_W    = 3,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned VEC_W   = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_LINES-N_SW-1:0] hw_irq_i,
  input logic                    sw_we_i,
  input logic [IDX_W-1:0]        sw_idx_i,
  input logic [ADDR_W-1:0]       entry_base_i,
  input logic                    ie_i,
  input logic                    dbg_i,
  input logic [N_LINES-1:0]      status_o,
  input logic                    has_work_o,
  input logic                    take_o,
  input logic [VEC_W-1:0]        vector_o,
  input logic [ADDR_W-1:0]       handler_o,
  input logic [N_LINES-1:0]      mask_q,
  input logic [SP_W-1:0]         spacing_q
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_hw_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> status_o[N_LINES-1:N_SW] == $past(hw_irq_i));

  p_sw_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && sw_idx_i >= IDX_W'(N_SW)) |=> $stable(status_o[N_SW-1:0]));

  p_idle_no_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_work_o |=> !take_o);

  p_take_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(ie_i && !dbg_i && has_work_o));

  p_take_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  p_vector_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (($past(status_o & mask_q)) >> vector_o) == N_LINES'(1));

  p_shared_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(spacing_q) == '0) |-> handler_o == $past(entry_base_i));
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(
  .N_LINES(N_LINES), .N_SW(N_SW), .IDX_W(IDX_W), .SP_W(SP_W),
  .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hw_irq_i(hw_irq_i), .sw_we_i(sw_we_i),
  .sw_idx_i(sw_idx_i), .entry_base_i(entry_base_i), .ie_i(ie_i),
  .dbg_i(dbg_i), .status_o(status_o), .has_work_o(has_work_o),
  .take_o(take_o), .vector_o(vector_o), .handler_o(handler_o),
  .mask_q(mask_q), .spacing_q(spacing_q)
);

// File: tb/test_irq_vector_arbiter.sv
`timescale 1ns/1ps
module test_irq_vector_arbiter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] hw_irq_i = '0;
  logic        sw_we_i = 1'b0;
  logic [4:0]  sw_idx_i = '0;
  logic        sw_level_i = 1'b0;
  logic        mask_we_i = 1'b0;
  logic [12:0] mask_i = '0;
  logic        spacing_we_i = 1'b0;
  logic [2:0]  spacing_i = '0;
  logic [31:0] entry_base_i = 32'h1c00_0000;
  logic        ie_i = 1'b0;
  logic        dbg_i = 1'b0;
  logic [12:0] status_o;
  logic        has_work_o, take_o;
  logic [3:0]  vector_o;
  logic [31:0] handler_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  irq_vector_arbiter i_irq_vector_arbiter (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input int sp, input int v);
    logic [31:0] s;
    s = (sp == 0) ? 32'd0 : (32'd4 << sp);
    return b + (32'd64 + 32'(v)) * s;
  endfunction

  // two ticks: load bit 0, then bit 1; hw lines captured throughout
  task automatic load_status(input logic [12:0] p);
    hw_irq_i = p[12:2];
    sw_we_i = 1'b1; sw_idx_i = 5'd0; sw_level_i = p[0];
    tick();
    sw_idx_i = 5'd1; sw_level_i = p[1];
    tick();
    sw_we_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R7: reset state while inputs are active
    hw_irq_i = '1;
    repeat (3) tick();
    chk("R7 status in reset", 32'(status_o), 0);
    chk("R7 take in reset", 32'(take_o), 0);
    chk("R7 has_work in reset", 32'(has_work_o), 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 all hw lines", 32'(status_o), 32'h1ffc);
    chk("R7 mask cleared", 32'(has_work_o), 0);

    // R1: walk each hardware line
    for (int i = 0; i < 11; i++) begin
      hw_irq_i = 11'(1 << i);
      tick();
      chk("R1 walking line", 32'(status_o), 32'(1 << (i + 2)));
    end
    hw_irq_i = '0;

    // R2: software bits and ignored indices
    sw_we_i = 1'b1; sw_idx_i = 5'd0; sw_level_i = 1'b1; tick();
    chk("R2 sw bit0 set", 32'(status_o), 32'h1);
    sw_idx_i = 5'd1; tick();
    chk("R2 sw bit1 set", 32'(status_o), 32'h3);
    sw_idx_i = 5'd0; sw_level_i = 1'b0; tick();
    chk("R2 sw bit0 clear", 32'(status_o), 32'h2);
    sw_level_i = 1'b1;
    for (int k = 2; k < 32; k++) begin
      sw_idx_i = 5'(k);
      tick();
      chk("R2 out of range idx ignored", 32'(status_o), 32'h2);
    end
    sw_we_i = 1'b0;

    // R3/R8: has_work independent of ie/dbg
    mask_we_i = 1'b1; mask_i = '1; tick(); mask_we_i = 1'b0;
    chk("R3 has_work with ie=0", 32'(has_work_o), 1);
    tick();
    chk("R4 no take with ie=0", 32'(take_o), 0);
    mask_we_i = 1'b1; mask_i = 13'h1; tick(); mask_we_i = 1'b0;
    chk("R8 mask excludes bit1", 32'(has_work_o), 0);
    mask_we_i = 1'b1; mask_i = '1; tick(); mask_we_i = 1'b0;

    // R4: debug blocks, then a single pulse
    ie_i = 1'b1; dbg_i = 1'b1;
    tick();
    chk("R3 has_work in debug", 32'(has_work_o), 1);
    tick();
    chk("R4 no take in debug", 32'(take_o), 0);
    dbg_i = 1'b0;
    tick();
    chk("R4 take after debug exit", 32'(take_o), 1);
    chk("R5 vector bit1", 32'(vector_o), 1);
    tick();
    chk("R4 take one cycle", 32'(take_o), 0);
    tick();
    chk("R4 no retake while held", 32'(take_o), 0);
    ie_i = 1'b0;

    // R5/R6: every vector under every spacing
    for (int sp = 0; sp < 8; sp++) begin
      spacing_we_i = 1'b1; spacing_i = 3'(sp); tick(); spacing_we_i = 1'b0;
      for (int v = 0; v < 13; v++) begin
        logic [12:0] p;
        p = 13'((1 << v) | ((v * 37 + sp * 11) & ((1 << v) - 1)));
        entry_base_i = 32'h1c00_0000 + 32'(sp << 16) + 32'(v << 4);
        load_status(p);
        ie_i = 1'b1;
        tick();
        chk("R4 take in sweep", 32'(take_o), 1);
        chk("R5 vector in sweep", 32'(vector_o), 32'(v));
        chk("R6 handler in sweep", handler_o, exp_addr(entry_base_i, sp, v));
        ie_i = 1'b0;
        tick();
      end
    end

    // R5: masked top line does not win
    mask_we_i = 1'b1; mask_i = 13'h0fff; tick(); mask_we_i = 1'b0;
    load_status(13'h1fff);
    ie_i = 1'b1; tick();
    chk("R5 masked top line skipped", 32'(vector_o), 11);
    chk("R6 handler spacing 7", handler_o, exp_addr(entry_base_i, 7, 11));
    ie_i = 1'b0; tick();

    // R7: reset clears mask and spacing
    rst_ni = 1'b0; tick(); rst_ni = 1'b1;
    hw_irq_i = 11'h400;
    tick();
    chk("R7 mask cleared after reset", 32'(has_work_o), 0);
    mask_we_i = 1'b1; mask_i = '1; tick(); mask_we_i = 1'b0;
    ie_i = 1'b1; tick();
    chk("R7 spacing cleared shared entry", handler_o, entry_base_i);
    chk("R5 vector after reset", 32'(vector_o), 12);
    ie_i = 1'b0; tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule